// File: doc/BRIEF.md
# Store Queue Forwarding Search

This block holds the stores in flight as a circular queue and answers, in the same cycle, whether a load can take its value from one of them. Each entry carries an address, a data word and two flags that say whether each of these has arrived. A store gets its entry at the tail when it is dispatched. Its address and its data arrive later and separately, each written straight into the entry by queue index. Stores leave from the head when they retire, and a flush moves the tail back to a chosen pointer.

A load presents its address and a tag. The tag is the tail pointer as it stood when the load was dispatched, so every store between the head and that tag is older than the load. The search is purely combinational, so it can run alongside the data cache lookup. Among the older stores whose resolved address equals the load address, the youngest one wins. If that store's data is present the block reports a hit and returns the data. If the data is not yet present the block reports a wait. If no older store matches, the block reports a miss and the cache value is used. A separate flag reports any older store whose address is still unknown, for schedulers that choose to stall on it.

Top module: `sq_fwd_search`

## Requirements
- R1: After reset the queue is empty, not full, its count is 0 and the allocation index is 0. A load then reports miss with no unknown-address flag.
- R2: An allocation takes the entry at the tail index and clears both of that entry's flags. It is ignored while the queue is full (count equal to the depth). The count never exceeds the depth.
- R3: A retire frees the head entry, and that store is no longer searched. A retire is ignored while the queue is empty.
- R4: An address write and a data write each update only the entry named by their own index. A data word that arrives before its address does not make the store match.
- R5: When the youngest older store with a matching address has its data, the load reports hit (exactly one of hit, wait and miss is high while a load is presented) and returns that store's data. Older matching stores are overridden.
- R6: Only stores older than the load take part. These are the live entries at offsets 0 up to (tag minus head) minus 1 from the head. Younger matching stores are ignored.
- R7: Age order follows the circular order starting at the head, so the correct store is picked when the live region wraps past the last index.
- R8: When the youngest older matching store has its address but no data yet, the load reports wait. This holds even if an older matching store has its data.
- R9: When no older store has a resolved, equal address, the load reports miss and the forwarded data is zero.
- R10: The unknown-address flag is high exactly when a load is presented and at least one older live store has no address yet.
- R11: A flush sets the tail pointer to the given pointer (including its wrap bit). Entries beyond it are no longer counted or searched. A flush cancels an allocation in the same cycle.
- R12: The search result depends only on the current inputs and the stored state, and is available in the same cycle the load is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate one store entry at the tail |
| alloc_idx | output | IDXW | Entry index the next allocation takes |
| sq_full | output | 1 | Queue holds DEPTH stores |
| sq_empty | output | 1 | Queue holds no store |
| sq_count | output | PW | Number of live stores |
| aw_we | input | 1 | Store address write |
| aw_idx | input | IDXW | Entry for the address write |
| aw_addr | input | AW | Resolved store address |
| dw_we | input | 1 | Store data write |
| dw_idx | input | IDXW | Entry for the data write |
| dw_data | input | DW | Store data |
| retire_req | input | 1 | Free the head entry |
| flush_req | input | 1 | Move the tail to flush_tail |
| flush_tail | input | PW | New tail pointer with wrap bit |
| ld_req | input | 1 | A load is searching this cycle |
| ld_tag | input | PW | Tail pointer seen at load dispatch |
| ld_addr | input | AW | Load address |
| fwd_hit | output | 1 | Data forwarded from a store |
| fwd_wait | output | 1 | Matching store has no data yet |
| fwd_miss | output | 1 | No older store matches |
| fwd_data | output | DW | Forwarded data, zero unless hit |
| older_unknown | output | 1 | An older store's address is unresolved |

## Verification
The bench builds the queue with a depth of 4 and 16-bit addresses and data. With this small depth, a few allocations fill the queue, and a handful of retires push the live region across the last index, so full, empty and wrapped searches all come up in a short directed run. The pointer wrap bit also turns over during the run, so load tags and flush pointers of 5 to 7 test the age span across the pointer wrap as well as the index wrap.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef enum logic [1:0] {
    SRCH_IDLE = 2'd0,
    SRCH_MISS = 2'd1,
    SRCH_HIT  = 2'd2,
    SRCH_WAIT = 2'd3
  } srch_e;

endpackage

// File: rtl/sq_ptrs.sv
module sq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PW   = IDXW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          retire_req,
  input  logic          flush_req,
  input  logic [PW-1:0] flush_tail,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] tail_ptr,
  output logic [PW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          alloc_fire,
  output logic          retire_fire
);

  function automatic logic [PW-1:0] ptr_gap(input logic [PW-1:0] hi, input logic [PW-1:0] lo);
    return hi - lo;
  endfunction

  assign count       = ptr_gap(tail_ptr, head_ptr);
  assign full        = (count == PW'(DEPTH));
  assign empty       = (count == '0);
  assign alloc_fire  = alloc_req && !full && !flush_req;
  assign retire_fire = retire_req && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (retire_fire) head_ptr <= head_ptr + PW'(1);
      if (flush_req)       tail_ptr <= flush_tail;
      else if (alloc_fire) tail_ptr <= tail_ptr + PW'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH)); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_req && !flush_req) |=> $stable(tail_ptr)); // R2
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && retire_req) |=> $stable(head_ptr)); // R3
  AST_FLUSH_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (ptr_gap(flush_tail, head_ptr) <= count)); // R11
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (tail_ptr == $past(flush_tail))); // R11

endmodule

// File: rtl/sq_entries.sv
module sq_entries #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_fire,
  input  logic [IDXW-1:0]           alloc_idx,
  input  logic                      aw_we,
  input  logic [IDXW-1:0]           aw_idx,
  input  logic [AW-1:0]             aw_addr,
  input  logic                      dw_we,
  input  logic [IDXW-1:0]           dw_idx,
  input  logic [DW-1:0]             dw_data,
  output logic [DEPTH-1:0]          addr_ok,
  output logic [DEPTH-1:0]          data_ok,
  output logic [DEPTH-1:0][AW-1:0]  addr_q,
  output logic [DEPTH-1:0][DW-1:0]  data_q
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic take, aset, dset;
    assign take = alloc_fire && (alloc_idx == IDXW'(e));
    assign aset = aw_we && (aw_idx == IDXW'(e));
    assign dset = dw_we && (dw_idx == IDXW'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_ok[e] <= 1'b0;
        data_ok[e] <= 1'b0;
        addr_q[e]  <= '0;
        data_q[e]  <= '0;
      end else begin
        if (aset)      addr_ok[e] <= 1'b1;
        else if (take) addr_ok[e] <= 1'b0;
        if (dset)      data_ok[e] <= 1'b1;
        else if (take) data_ok[e] <= 1'b0;
        if (aset) addr_q[e] <= aw_addr;
        if (dset) data_q[e] <= dw_data;
      end
    end
  end

  AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    aw_we |=> (addr_ok[$past(aw_idx)] && addr_q[$past(aw_idx)] == $past(aw_addr))); // R4
  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dw_we |=> (data_ok[$past(dw_idx)] && data_q[$past(dw_idx)] == $past(dw_data))); // R4
  AST_ALLOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !(aw_we && aw_idx == alloc_idx)) |=> !addr_ok[$past(alloc_idx)]); // R2

endmodule

// File: rtl/sq_pick.sv
module sq_pick #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic [IDXW-1:0]  head_idx,
  input  logic [DEPTH-1:0] cand,
  output logic             found,
  output logic [IDXW-1:0]  sel_idx
);

  // Walk from the head (oldest) upward; the last candidate seen is the youngest.
  always_comb begin
    logic [IDXW-1:0] j;
    found   = 1'b0;
    sel_idx = head_idx;
    for (int k = 0; k < DEPTH; k++) begin
      j = head_idx + IDXW'(k);
      if (cand[j]) begin
        found   = 1'b1;
        sel_idx = j;
      end
    end
  end

endmodule

// File: rtl/sq_fwd_search.sv
module sq_fwd_search #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int PW   = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_req,
  output logic [IDXW-1:0] alloc_idx,
  output logic            sq_full,
  output logic            sq_empty,
  output logic [PW-1:0]   sq_count,
  input  logic            aw_we,
  input  logic [IDXW-1:0] aw_idx,
  input  logic [AW-1:0]   aw_addr,
  input  logic            dw_we,
  input  logic [IDXW-1:0] dw_idx,
  input  logic [DW-1:0]   dw_data,
  input  logic            retire_req,
  input  logic            flush_req,
  input  logic [PW-1:0]   flush_tail,
  input  logic            ld_req,
  input  logic [PW-1:0]   ld_tag,
  input  logic [AW-1:0]   ld_addr,
  output logic            fwd_hit,
  output logic            fwd_wait,
  output logic            fwd_miss,
  output logic [DW-1:0]   fwd_data,
  output logic            older_unknown
);
  import sq_pkg::*;

  logic [PW-1:0]          head_ptr, tail_ptr;
  logic                   alloc_fire, retire_fire;
  logic [DEPTH-1:0]       addr_ok, data_ok;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [IDXW-1:0]        head_idx;
  logic [PW-1:0]          span_raw, span_eff;
  logic [DEPTH-1:0]       older, cand;
  logic                   found;
  logic [IDXW-1:0]        sel_idx;
  srch_e                  srch;

  function automatic logic [IDXW-1:0] slot_off(input logic [IDXW-1:0] idx, input logic [IDXW-1:0] hd);
    return idx - hd;
  endfunction

  function automatic logic [PW-1:0] age_span(input logic [PW-1:0] tag, input logic [PW-1:0] hd,
                                             input logic [PW-1:0] live);
    logic [PW-1:0] s;
    s = tag - hd;
    return (s > live) ? live : s;
  endfunction

  sq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .retire_req(retire_req),
    .flush_req(flush_req), .flush_tail(flush_tail), .head_ptr(head_ptr),
    .tail_ptr(tail_ptr), .count(sq_count), .full(sq_full), .empty(sq_empty),
    .alloc_fire(alloc_fire), .retire_fire(retire_fire)
  );

  assign alloc_idx = tail_ptr[IDXW-1:0];
  assign head_idx  = head_ptr[IDXW-1:0];

  sq_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ent (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_idx(alloc_idx),
    .aw_we(aw_we), .aw_idx(aw_idx), .aw_addr(aw_addr),
    .dw_we(dw_we), .dw_idx(dw_idx), .dw_data(dw_data),
    .addr_ok(addr_ok), .data_ok(data_ok), .addr_q(addr_q), .data_q(data_q)
  );

  assign span_raw = ld_tag - head_ptr;
  assign span_eff = age_span(ld_tag, head_ptr, sq_count);

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign older[e] = ({1'b0, slot_off(IDXW'(e), head_idx)} < span_eff);
    assign cand[e]  = older[e] && addr_ok[e] && (addr_q[e] == ld_addr);
  end

  sq_pick #(.DEPTH(DEPTH)) u_pick (
    .head_idx(head_idx), .cand(cand), .found(found), .sel_idx(sel_idx)
  );

  always_comb begin
    if (!ld_req)             srch = SRCH_IDLE;
    else if (!found)         srch = SRCH_MISS;
    else if (data_ok[sel_idx]) srch = SRCH_HIT;
    else                     srch = SRCH_WAIT;
  end

  assign fwd_hit       = (srch == SRCH_HIT);
  assign fwd_wait      = (srch == SRCH_WAIT);
  assign fwd_miss      = (srch == SRCH_MISS);
  assign fwd_data      = fwd_hit ? data_q[sel_idx] : '0;
  assign older_unknown = ld_req && |(older & ~addr_ok);

  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |-> ($countones({fwd_hit, fwd_wait, fwd_miss}) == 1)); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req |-> ({fwd_hit, fwd_wait, fwd_miss, older_unknown} == 4'b0)); // R12
  AST_PICK_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_hit || fwd_wait) |-> ({1'b0, slot_off(sel_idx, head_idx)} < span_raw)); // R6
  AST_PICK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_hit || fwd_wait) |-> (addr_ok[sel_idx] && addr_q[sel_idx] == ld_addr)); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_hit |-> (fwd_data == '0)); // R9
  AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && sq_empty) |-> (fwd_miss && !older_unknown)); // R10

endmodule

// File: tb/sq_fwd_search_test.sv
`timescale 1ns/1ps
module sq_fwd_search_test;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int IDXW = 2;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 0, aw_we = 0, dw_we = 0, retire_req = 0, flush_req = 0, ld_req = 0;
  logic [IDXW-1:0] aw_idx = '0, dw_idx = '0;
  logic [AW-1:0] aw_addr = '0, ld_addr = '0;
  logic [DW-1:0] dw_data = '0;
  logic [PW-1:0] flush_tail = '0, ld_tag = '0;
  logic [IDXW-1:0] alloc_idx;
  logic sq_full, sq_empty, fwd_hit, fwd_wait, fwd_miss, older_unknown;
  logic [PW-1:0] sq_count;
  logic [DW-1:0] fwd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sq_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_idx(alloc_idx),
    .sq_full(sq_full), .sq_empty(sq_empty), .sq_count(sq_count),
    .aw_we(aw_we), .aw_idx(aw_idx), .aw_addr(aw_addr),
    .dw_we(dw_we), .dw_idx(dw_idx), .dw_data(dw_data),
    .retire_req(retire_req), .flush_req(flush_req), .flush_tail(flush_tail),
    .ld_req(ld_req), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .fwd_hit(fwd_hit), .fwd_wait(fwd_wait), .fwd_miss(fwd_miss),
    .fwd_data(fwd_data), .older_unknown(older_unknown)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // status code: 1 hit, 2 wait, 4 miss
  task automatic probe(input string req, input logic [PW-1:0] tag, input logic [AW-1:0] a,
                       input logic [2:0] st, input logic [DW-1:0] d, input logic unk);
    @(negedge clk);
    ld_req = 1; ld_tag = tag; ld_addr = a;
    #1;
    chk(req, {29'd0, fwd_miss, fwd_wait, fwd_hit}, {29'd0, st});
    chk(req, {16'd0, fwd_data}, {16'd0, d});
    chk(req, {31'd0, older_unknown}, {31'd0, unk});
    ld_req = 0;
  endtask

  task automatic do_alloc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); alloc_req = 1;
      @(posedge clk); #1; alloc_req = 0;
    end
  endtask

  task automatic do_retire(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); retire_req = 1;
      @(posedge clk); #1; retire_req = 0;
    end
  endtask

  task automatic wr_addr(input logic [IDXW-1:0] i, input logic [AW-1:0] a);
    @(negedge clk); aw_we = 1; aw_idx = i; aw_addr = a;
    @(posedge clk); #1; aw_we = 0;
  endtask

  task automatic wr_data(input logic [IDXW-1:0] i, input logic [DW-1:0] d);
    @(negedge clk); dw_we = 1; dw_idx = i; dw_data = d;
    @(posedge clk); #1; dw_we = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 empty", {31'd0, sq_empty}, 1);
    chk("R1 full", {31'd0, sq_full}, 0);
    chk("R1 count", {29'd0, sq_count}, 0);
    chk("R1 alloc_idx", {30'd0, alloc_idx}, 0);
    probe("R1 load", 3'd0, 16'h10, 3'b100, 16'h0, 1'b0);
  endtask

  task automatic t_basic;
    do_alloc(3);
    chk("R2 count3", {29'd0, sq_count}, 3);
    chk("R2 alloc_idx", {30'd0, alloc_idx}, 3);
    wr_addr(2'd0, 16'h10); wr_addr(2'd1, 16'h20); wr_addr(2'd2, 16'h10);
    wr_data(2'd0, 16'hA0); wr_data(2'd1, 16'hA1); wr_data(2'd2, 16'hA2);
    probe("R5 youngest", 3'd3, 16'h10, 3'b001, 16'hA2, 1'b0);
    probe("R6 younger ignored", 3'd2, 16'h10, 3'b001, 16'hA0, 1'b0);
    probe("R9 no match", 3'd3, 16'h30, 3'b100, 16'h0, 1'b0);
    probe("R6 none older", 3'd0, 16'h10, 3'b100, 16'h0, 1'b0);
  endtask

  task automatic t_full_wait;
    do_alloc(1);
    chk("R2 full", {31'd0, sq_full}, 1);
    probe("R10 unknown", 3'd4, 16'h10, 3'b001, 16'hA2, 1'b1);
    do_alloc(1);
    chk("R2 full ignore", {29'd0, sq_count}, 4);
    wr_addr(2'd3, 16'h10);
    probe("R8 wait", 3'd4, 16'h10, 3'b010, 16'h0, 1'b0);
    wr_data(2'd3, 16'hA3);
    probe("R5 hit after data", 3'd4, 16'h10, 3'b001, 16'hA3, 1'b0);
  endtask

  task automatic t_retire_wrap;
    do_retire(2);
    chk("R3 count", {29'd0, sq_count}, 2);
    probe("R3 retired gone", 3'd4, 16'h20, 3'b100, 16'h0, 1'b0);
    chk("R2 alloc_idx wrap", {30'd0, alloc_idx}, 0);
    do_alloc(2);
    wr_data(2'd0, 16'hB0);
    probe("R4 data only", 3'd6, 16'h10, 3'b001, 16'hA3, 1'b1);
    wr_addr(2'd0, 16'h10); wr_addr(2'd1, 16'h40); wr_data(2'd1, 16'hB1);
    probe("R7 wrap youngest", 3'd6, 16'h10, 3'b001, 16'hB0, 1'b0);
    probe("R7 wrap span", 3'd5, 16'h40, 3'b100, 16'h0, 1'b0);
    probe("R7 wrap last", 3'd6, 16'h40, 3'b001, 16'hB1, 1'b0);
  endtask

  task automatic t_flush;
    @(negedge clk); flush_req = 1; flush_tail = 3'd5; alloc_req = 1;
    @(posedge clk); #1; flush_req = 0; alloc_req = 0;
    chk("R11 count", {29'd0, sq_count}, 3);
    chk("R11 alloc_idx", {30'd0, alloc_idx}, 1);
    probe("R11 flushed gone", 3'd6, 16'h40, 3'b100, 16'h0, 1'b0);
    do_alloc(1);
    probe("R2 flags cleared", 3'd6, 16'h40, 3'b100, 16'h0, 1'b1);
  endtask

  task automatic t_empty;
    do_retire(4);
    chk("R3 empty", {31'd0, sq_empty}, 1);
    do_retire(1);
    chk("R3 empty ignore", {29'd0, sq_count}, 0);
    do_alloc(1);
    chk("R3 head held", {29'd0, sq_count}, 1);
    chk("R3 alloc_idx", {30'd0, alloc_idx}, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_basic;
    t_full_wait;
    t_retire_wrap;
    t_flush;
    t_empty;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule